// File: doc/BRIEF.md
# Fixed-priority platform interrupt router

This block gathers level-sensitive interrupt requests from a small set of peripheral sources and routes them to a set of processor contexts. A context is one privilege mode (machine or supervisor) of one hardware thread, so the context count is twice the hart count, up to 32. Each source passes through a gateway that holds one pending bit and one claimed flag. Each context holds an enable mask, and the block drives one interrupt line per context. That line is high while any source is both pending and enabled for the context.

Each context owns one register access port. Software on a context takes an interrupt by reading its claim register. The read returns the lowest-numbered source that is pending and enabled for that context, clears that source's pending bit and marks the source as claimed. Writing the source number back to the same register completes the source, and its level may then raise the pending bit again. Source priorities and context thresholds are present in the address map as constants. The source inputs are assumed to be synchronous to `clk` already.

Source numbering is fixed: 0 means "no interrupt", 1 is the memory ECC error, 2 the quad serial flash controller, 3 the UART, 4 the system-register doorbell, 5 the expanded serial interface and 6 the GPIO change. `src_level` bit i-1 carries source i.

Every access port is a valid/ready request channel followed by a one-cycle response. `req_ready` is held high, so the block never applies back-pressure. A request is accepted on every rising edge where its `req_valid` is high. The response has no ready signal: the requester must take `rsp_valid`/`rsp_rdata` in the cycle in which they are shown.

Top module: `irq_router`

## Requirements
- R1: After reset, every pending bit, claimed flag and enable mask is zero. All `irq` lines are low and no `rsp_valid` is high.
- R2: A source whose level is high while it is neither pending nor claimed sets its pending bit at the next rising edge. The pending register (byte address 0x1000) shows source i at bit i, and bit 0 reads 0.
- R3: `irq[c]` is high exactly when some source is pending and has its bit set in context c's enable mask.
- R4: A claim read (byte address 0x200004 + 0x1000*c through port c) returns the lowest-numbered source that is pending and enabled for context c. It returns 0 when no source is eligible.
- R5: A claim clears the source's pending bit. While the source stays claimed, its pending bit stays low even if its level remains high.
- R6: When several ports claim in the same cycle, they are served in increasing context order. Each later port gets the lowest source still eligible after the earlier grants, or 0. No source ID is given to two ports.
- R7: A write of a claimed source number to any context's claim register (through that context's port) releases the source. If the level is still high, the pending bit returns one edge after the release.
- R8: A completion write is ignored when the written 32-bit value is 0, is above the source count, or names a source that is not claimed.
- R9: The priority word at byte address 4*i reads 1 for sources 1..6 and 0 for ID 0 and for unused IDs. Each threshold word (0x200000 + 0x1000*c) reads 0. Writes to either region change nothing.
- R10: Context c's enable mask is at byte address 0x2000 + 0x80*c. Bits 1..6 are the sources and bit 0 always reads 0. The mask is writable only through port c. Through any other port, that address reads 0 and writes to it are ignored.
- R11: `req_ready` is always high. Each accepted request gives `rsp_valid` on the same port in the next cycle only. Write responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | NUM_SRC | Source levels; bit i-1 is source i |
| req_valid | input | NUM_CTX | Request valid, one per context port |
| req_ready | output | NUM_CTX | Request ready, always high |
| req_write | input | NUM_CTX | 1 = write, 0 = read |
| req_addr | input | NUM_CTX*ADDR_W | Byte address per port, port k at bits [k*ADDR_W +: ADDR_W] |
| req_wdata | input | NUM_CTX*DATA_W | Write data per port |
| rsp_valid | output | NUM_CTX | Response valid, one cycle after acceptance |
| rsp_rdata | output | NUM_CTX*DATA_W | Response data per port |
| irq | output | NUM_CTX | Interrupt line per context |

## Verification
The hardest situation to reach is a claim race. Several contexts have to read their claim registers in the very same cycle, with overlapping enable masks and some sources still held claimed from an earlier round. The bench places requests on several ports before a single acceptance edge. It queues the expected IDs in port order, so the scoreboard sees whether lower contexts are served first and later ones fall through to the next source or 0. It also keeps source levels high across claim, false completion and true completion, and reads the pending register between each step. This shows that a held level stays masked until the right release, and that completion values which only alias a claimed ID in their low bits are rejected.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int ADDR_W = 22;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_PEND,
    RG_ENAB,
    RG_THRESH,
    RG_CLAIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [9:0] ctx;
    logic [9:0] idx;
  } reg_dec_t;

  // Word-aligned byte address decode into region, context and index.
  function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_dec_t d;
    d.kind = RG_NONE;
    d.ctx  = '0;
    d.idx  = '0;
    if (a[1:0] == 2'b00) begin
      if (a[21]) begin
        d.ctx = {1'b0, a[20:12]};
        if (a[11:0] == 12'h000)      d.kind = RG_THRESH;
        else if (a[11:0] == 12'h004) d.kind = RG_CLAIM;
      end else if (a[20:12] == 9'd0) begin
        d.kind = RG_PRIO;
        d.idx  = a[11:2];
      end else if (a[20:12] == 9'd1) begin
        if (a[11:2] == 10'd0) d.kind = RG_PEND;
      end else if (a[20:12] == 9'd2) begin
        d.ctx = {5'b0, a[11:7]};
        if (a[6:2] == 5'd0) d.kind = RG_ENAB;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/irq_gateway.sv
`timescale 1ns/1ps
module irq_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic take,
  input  logic done,
  output logic pending,
  output logic claimed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      claimed <= 1'b0;
    end else if (take) begin
      pending <= 1'b0;
      claimed <= 1'b1;
    end else begin
      if (done) claimed <= 1'b0;
      if (level && !pending && !claimed) pending <= 1'b1;
    end
  end

  // R5: a claimed source never shows pending
  a_r5_masked_while_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    claimed |-> !pending);
  // R5: a claim moves the source from pending to claimed
  a_r5_take_marks: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (claimed && !pending));
  // R7: completion releases the source
  a_r7_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !take) |=> !claimed);
  // R2: an idle source with a high level becomes pending
  a_r2_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (level && !pending && !claimed && !take) |=> pending);
endmodule

// File: rtl/irq_claim_arb.sv
`timescale 1ns/1ps
module irq_claim_arb #(
  parameter  int NUM_SRC = 6,
  parameter  int NUM_CTX = 4,
  localparam int IDW     = $clog2(NUM_SRC + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         pending,
  input  logic [NUM_CTX*NUM_SRC-1:0] en_flat,
  input  logic [NUM_CTX-1:0]         claim_rd,
  output logic [NUM_CTX*IDW-1:0]     id_flat,
  output logic [NUM_SRC-1:0]         take
);
  // avail[k] is what remains for context k after lower contexts took theirs
  logic [NUM_SRC-1:0] avail [NUM_CTX+1];
  assign avail[0] = pending;

  for (genvar k = 0; k < NUM_CTX; k++) begin : g_stage
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] grant_k;
    logic [IDW-1:0]     id_k;

    assign elig = avail[k] & en_flat[k*NUM_SRC +: NUM_SRC];

    always_comb begin
      grant_k = '0;
      id_k    = '0;
      if (claim_rd[k]) begin
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
          if (elig[i]) begin
            grant_k = NUM_SRC'(1) << i;
            id_k    = IDW'(i + 1);
          end
        end
      end
    end

    assign avail[k+1] = avail[k] & ~grant_k;
    assign id_flat[k*IDW +: IDW] = id_k;

    // R4: a granted ID is pending and enabled for the claiming context
    a_r4_id_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      (id_k != '0) |-> (claim_rd[k] && pending[int'(id_k) - 1]
                        && en_flat[k*NUM_SRC + int'(id_k) - 1]));

    for (genvar j = k + 1; j < NUM_CTX; j++) begin : g_pair
      // R6: no source ID reaches two contexts in one cycle
      a_r6_unique_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (id_k != '0 && id_flat[j*IDW +: IDW] != '0) |-> (id_k != id_flat[j*IDW +: IDW]));
    end
  end

  assign take = pending & ~avail[NUM_CTX];
endmodule

// File: rtl/irq_regport.sv
`timescale 1ns/1ps
module irq_regport
  import irq_pkg::*;
#(
  parameter  int NUM_SRC = 6,
  parameter  int CTX     = 0,
  localparam int IDW     = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [NUM_SRC-1:0] pending,
  input  logic [NUM_SRC-1:0] claimed,
  input  logic [NUM_SRC-1:0] en_own,
  input  logic [IDW-1:0]     claim_id,
  output logic               claim_rd,
  output logic               en_we,
  output logic [NUM_SRC-1:0] en_wdata,
  output logic [NUM_SRC-1:0] done,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata
);
  reg_dec_t          dec;
  logic              own;
  logic              rd_acc;
  logic              wr_acc;
  logic [DATA_W-1:0] rd_data;

  assign dec       = decode_addr(req_addr);
  assign own       = (dec.ctx == 10'(CTX));
  assign req_ready = 1'b1;
  assign rd_acc    = req_valid && !req_write;
  assign wr_acc    = req_valid && req_write;

  assign claim_rd = rd_acc && own && (dec.kind == RG_CLAIM);
  assign en_we    = wr_acc && own && (dec.kind == RG_ENAB);
  assign en_wdata = req_wdata[NUM_SRC:1];

  // Completion: full-width value must equal a claimed source number
  always_comb begin
    done = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      done[i] = wr_acc && own && (dec.kind == RG_CLAIM)
                && (req_wdata == DATA_W'(i + 1)) && claimed[i];
    end
  end

  always_comb begin
    rd_data = '0;
    case (dec.kind)
      RG_PRIO:  rd_data[0] = (dec.idx >= 10'd1) && (dec.idx <= 10'(NUM_SRC));
      RG_PEND:  rd_data[NUM_SRC:1] = pending;
      RG_ENAB:  if (own) rd_data[NUM_SRC:1] = en_own;
      RG_CLAIM: if (own) rd_data[IDW-1:0] = claim_id;
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_acc ? rd_data : '0;
    end
  end

  // R11: exactly one response, one cycle after acceptance
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R9: a priority read returns 0 or 1 only
  a_r9_prio_const: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && dec.kind == RG_PRIO) |=> (rsp_rdata[DATA_W-1:1] == '0));
  // R10: bit 0 of an enable read is always clear
  a_r10_en_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && dec.kind == RG_ENAB) |=> !rsp_rdata[0]);
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
  import irq_pkg::*;
#(
  parameter  int NUM_SRC = 6,
  parameter  int NUM_CTX = 4,
  localparam int IDW     = $clog2(NUM_SRC + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_level,
  input  logic [NUM_CTX-1:0]        req_valid,
  output logic [NUM_CTX-1:0]        req_ready,
  input  logic [NUM_CTX-1:0]        req_write,
  input  logic [NUM_CTX*ADDR_W-1:0] req_addr,
  input  logic [NUM_CTX*DATA_W-1:0] req_wdata,
  output logic [NUM_CTX-1:0]        rsp_valid,
  output logic [NUM_CTX*DATA_W-1:0] rsp_rdata,
  output logic [NUM_CTX-1:0]        irq
);
  logic [NUM_SRC-1:0]         pending;
  logic [NUM_SRC-1:0]         claimed;
  logic [NUM_SRC-1:0]         take;
  logic [NUM_SRC-1:0]         done_all;
  logic [NUM_CTX*NUM_SRC-1:0] en_flat;
  logic [NUM_CTX*NUM_SRC-1:0] done_flat;
  logic [NUM_CTX*IDW-1:0]     id_flat;
  logic [NUM_CTX-1:0]         claim_rd;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_gateway u_gw (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (src_level[i]),
      .take    (take[i]),
      .done    (done_all[i]),
      .pending (pending[i]),
      .claimed (claimed[i])
    );
  end

  for (genvar k = 0; k < NUM_CTX; k++) begin : g_ctx
    logic [NUM_SRC-1:0] en_q;
    logic               en_we;
    logic [NUM_SRC-1:0] en_wdata;

    always_ff @(posedge clk) begin
      if (!rst_n)     en_q <= '0;
      else if (en_we) en_q <= en_wdata;
    end

    assign en_flat[k*NUM_SRC +: NUM_SRC] = en_q;
    assign irq[k] = |(pending & en_q);

    irq_regport #(
      .NUM_SRC (NUM_SRC),
      .CTX     (k)
    ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid[k]),
      .req_ready (req_ready[k]),
      .req_write (req_write[k]),
      .req_addr  (req_addr[k*ADDR_W +: ADDR_W]),
      .req_wdata (req_wdata[k*DATA_W +: DATA_W]),
      .pending   (pending),
      .claimed   (claimed),
      .en_own    (en_q),
      .claim_id  (id_flat[k*IDW +: IDW]),
      .claim_rd  (claim_rd[k]),
      .en_we     (en_we),
      .en_wdata  (en_wdata),
      .done      (done_flat[k*NUM_SRC +: NUM_SRC]),
      .rsp_valid (rsp_valid[k]),
      .rsp_rdata (rsp_rdata[k*DATA_W +: DATA_W])
    );

    // R3: interrupt line follows pending-and-enabled state
    a_r3_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq[k]);
  end

  always_comb begin
    done_all = '0;
    for (int k = 0; k < NUM_CTX; k++) done_all |= done_flat[k*NUM_SRC +: NUM_SRC];
  end

  irq_claim_arb #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX)
  ) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pending  (pending),
    .en_flat  (en_flat),
    .claim_rd (claim_rd),
    .id_flat  (id_flat),
    .take     (take)
  );

  // R8: a completion only ever touches claimed sources
  a_r8_done_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    (done_all & ~claimed) == '0);
endmodule

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
  import irq_pkg::*;
  localparam int NS = 6;
  localparam int NC = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NS-1:0]        src_level = '0;
  logic [NC-1:0]        req_valid = '0;
  logic [NC-1:0]        req_ready;
  logic [NC-1:0]        req_write = '0;
  logic [NC*ADDR_W-1:0] req_addr = '0;
  logic [NC*DATA_W-1:0] req_wdata = '0;
  logic [NC-1:0]        rsp_valid;
  logic [NC*DATA_W-1:0] rsp_rdata;
  logic [NC-1:0]        irq;

  int nchk = 0;
  int nfail = 0;
  int          qp[$];
  logic [31:0] qe[$];
  string       qt[$];

  always #2.5 clk = ~clk;

  irq_router #(.NUM_SRC(NS), .NUM_CTX(NC)) i_irq_router (
    .clk(clk), .rst_n(rst_n), .src_level(src_level),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] a_prio(input int id); return ADDR_W'(4 * id); endfunction
  function automatic logic [ADDR_W-1:0] a_en(input int c); return ADDR_W'(32'h2000 + 32'h80 * c); endfunction
  function automatic logic [ADDR_W-1:0] a_thr(input int c); return ADDR_W'(32'h200000 + 32'h1000 * c); endfunction
  function automatic logic [ADDR_W-1:0] a_clm(input int c); return ADDR_W'(32'h200004 + 32'h1000 * c); endfunction
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(32'h1000);

  // Driver: stage a request on port p and queue its expected response
  task automatic put(input int p, input bit wr, input logic [ADDR_W-1:0] a,
                     input logic [31:0] d, input logic [31:0] exp, input string tag);
    req_valid[p] = 1'b1;
    req_write[p] = wr;
    req_addr[p*ADDR_W +: ADDR_W] = a;
    req_wdata[p*DATA_W +: DATA_W] = d;
    qp.push_back(p);
    qe.push_back(wr ? 32'h0 : exp);
    qt.push_back(tag);
  endtask

  task automatic go();
    @(posedge clk); #1;
    req_valid = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: pop expected responses in port order
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NC; p++) begin
        if (rsp_valid[p]) begin
          if (qp.size() == 0) begin
            check("R11 unexpected response", 32'(p), 32'hFFFF_FFFF);
          end else begin
            check({qt[0], " port"}, 32'(qp[0]), 32'(p));
            check(qt[0], rsp_rdata[p*DATA_W +: DATA_W], qe[0]);
            void'(qp.pop_front());
            void'(qe.pop_front());
            void'(qt.pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 irq after reset", 32'(irq), 32'h0);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    check("R11 req_ready", 32'(req_ready), 32'hF);
    put(0, 0, A_PEND, 0, 32'h0, "R1 pending after reset"); go();
    put(0, 0, a_en(0), 0, 32'h0, "R1 enable after reset"); go();
    put(1, 0, a_clm(1), 0, 32'h0, "R1 claim after reset"); go();

    // R9 constant priority and threshold
    put(0, 0, a_prio(0), 0, 32'h0, "R9 prio id0"); go();
    put(0, 0, a_prio(3), 0, 32'h1, "R9 prio id3"); go();
    put(0, 1, a_prio(3), 32'h5, 0, "R11 write rsp"); go();
    put(0, 0, a_prio(3), 0, 32'h1, "R9 prio after write"); go();
    put(2, 0, a_prio(6), 0, 32'h1, "R9 prio id6"); go();
    put(2, 0, a_prio(7), 0, 32'h0, "R9 prio id7"); go();
    put(1, 1, a_thr(1), 32'h7, 0, "R11 write rsp"); go();
    put(1, 0, a_thr(1), 0, 32'h0, "R9 threshold"); go();

    // R10 enable masks
    put(0, 1, a_en(0), 32'hFF, 0, "R11 write rsp"); go();
    put(0, 0, a_en(0), 0, 32'h7E, "R10 enable readback"); go();
    put(1, 0, a_en(0), 0, 32'h0, "R10 foreign enable read"); go();
    put(1, 1, a_en(0), 32'h0, 0, "R11 write rsp"); go();
    put(0, 0, a_en(0), 0, 32'h7E, "R10 foreign write ignored"); go();
    put(1, 1, a_en(1), 32'h7E, 0, "R11 write rsp");
    put(2, 1, a_en(2), 32'h10, 0, "R11 write rsp"); go();

    // R2/R3 sources 3 and 5
    src_level = 6'b010100;
    idle(1);
    put(3, 0, A_PEND, 0, 32'h28, "R2 pending 3,5"); go();
    check("R3 irq with 3,5", 32'(irq), 32'h3);

    // R6/R4 simultaneous claims on all ports
    put(0, 0, a_clm(0), 0, 32'd3, "R6 ctx0 gets 3");
    put(1, 0, a_clm(1), 0, 32'd5, "R6 ctx1 gets next 5");
    put(2, 0, a_clm(2), 0, 32'd0, "R6 ctx2 gets 0");
    put(3, 0, a_clm(3), 0, 32'd0, "R4 ctx3 disabled"); go();
    put(0, 0, A_PEND, 0, 32'h0, "R5 pending cleared by claim"); go();
    idle(3);
    put(0, 0, A_PEND, 0, 32'h0, "R5 held level masked"); go();
    check("R5 irq while claimed", 32'(irq), 32'h0);

    // R8 bogus completions
    put(2, 1, a_clm(2), 32'd7, 0, "R11 write rsp"); go();
    put(2, 1, a_clm(2), 32'h13, 0, "R11 write rsp"); go();
    put(2, 1, a_clm(2), 32'd0, 0, "R11 write rsp"); go();
    put(2, 1, a_clm(2), 32'd4, 0, "R11 write rsp"); go();
    idle(2);
    put(0, 0, A_PEND, 0, 32'h0, "R8 bad completions ignored"); go();

    // R7 real completion of 3 from another context
    put(1, 1, a_clm(1), 32'd3, 0, "R11 write rsp"); go();
    idle(1);
    put(0, 0, A_PEND, 0, 32'h08, "R7 source 3 pending again"); go();
    check("R7 irq after release", 32'(irq), 32'h3);

    // R4 lowest first with source 4 joining
    src_level[3] = 1'b1;
    idle(1);
    check("R3 irq with 3,4", 32'(irq), 32'h7);
    put(0, 0, a_clm(0), 0, 32'd3, "R4 lowest 3"); go();
    put(0, 0, a_clm(0), 0, 32'd4, "R4 next 4"); go();
    put(0, 0, a_clm(0), 0, 32'd0, "R4 none left"); go();

    // R7 release with levels low
    src_level = '0;
    put(0, 1, a_clm(0), 32'd5, 0, "R11 write rsp");
    put(1, 1, a_clm(1), 32'd3, 0, "R11 write rsp");
    put(2, 1, a_clm(2), 32'd4, 0, "R11 write rsp"); go();
    idle(2);
    put(0, 0, A_PEND, 0, 32'h0, "R7 low level stays clear"); go();

    // R6 second race after release
    src_level = 6'b100001;
    idle(1);
    put(3, 0, A_PEND, 0, 32'h42, "R2 pending 1,6"); go();
    put(0, 0, a_clm(0), 0, 32'd1, "R6 ctx0 gets 1");
    put(1, 0, a_clm(1), 0, 32'd6, "R6 ctx1 gets 6"); go();
    check("R3 irq all claimed", 32'(irq), 32'h0);

    idle(3);
    check("R11 all responses seen", 32'(qp.size()), 32'h0);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule